// File: doc/BRIEF.md
# Smooth Calibration Pulse Trimmer

This block trims the rate of a real-time-clock tick stream. It removes or inserts tick pulses at fixed points of a repeating calibration window, and the result is a gated tick enable that drives the prescalers downstream. The raw oscillator pulse arrives as a one-cycle strobe `tick_in` in the system clock domain. `tick_out` is the corrected strobe.

Software writes a correction word in one cycle. The word holds an add flag, a mask count and two window-select bits. The net number of pulses gained per window is 2^MASK_W × add − mask. With the default 9-bit mask this covers −511 to +512 pulses. At a 32768 Hz tick over a 2^20-tick window, one pulse is about 0.954 ppm.

Internally the block turns the word into a single event count N and a direction. Each window is split into 2^MASK_W equal slots, and the slot index is bit-reversed. The block acts in a slot when the reversed index is below N, which spreads the events evenly over the window. A new word is held pending until the next window boundary, and `busy` is high while it waits. Consecutive `tick_in` strobes must be at least two system cycles apart, because an inserted pulse uses the cycle after the tick that triggered it.

Top module: `rtc_smooth_trim`

## Requirements
- R1: After reset, `tick_out` and `busy` are low and the active word is zero: add 0, mask 0, longest window.
- R2: The window length in ticks is 2^(CNT_W−2) when the short select is set, whatever the middle select. It is 2^(CNT_W−1) when only the middle select is set, and 2^CNT_W when neither is set.
- R3: With the add flag clear, exactly `mask` tick pulses are dropped from each window.
- R4: With the add flag set, exactly 2^MASK_W − `mask` pulses are inserted in each window. Each inserted pulse appears on `tick_out` in the cycle after the pulse of the tick that triggered it.
- R5: Over each window, the number of `tick_out` pulses equals the window length plus 2^MASK_W × add − mask. This holds at both extremes: add 1 with mask 0, and add 0 with mask 2^MASK_W − 1.
- R6: With add and mask both zero, `tick_out` copies `tick_in` delayed by exactly one clock cycle.
- R7: The events are spread evenly. The first half of each window carries ceil(N/2) of the N events.
- R8: A written word takes effect only at the next window boundary. `busy` is high from the cycle after the write until the cycle after the last tick of the current window.
- R9: `tick_out` is high only in the cycle after an accepted `tick_in` or in the cycle after a pending insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Raw oscillator pulse, one-cycle strobe |
| cfg_we | input | 1 | Write strobe for the correction word |
| cfg_add | input | 1 | Add flag: insert 2^MASK_W pulses per window |
| cfg_mask | input | MASK_W | Pulses removed from the add amount per window |
| cfg_sel_short | input | 1 | Selects the shortest window (priority) |
| cfg_sel_mid | input | 1 | Selects the middle window |
| tick_out | output | 1 | Corrected tick enable |
| busy | output | 1 | A written word is waiting for the window boundary |

## Verification
The bench builds the block with CNT_W = 11 and the default 9-bit mask. This makes the windows 512, 1024 and 2048 ticks long. With the shortest window, every tick is its own slot, so whole windows at every select fit in a short run. Both correction extremes and several middle values can then be counted pulse by pulse against the arithmetic of R5 and R7. The zero word is also checked cycle by cycle for the one-cycle pass-through.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   typedef enum logic [1:0] {
      WIN_LONG  = 2'd0,
      WIN_MID   = 2'd1,
      WIN_SHORT = 2'd2
   } win_e;

   function automatic win_e win_decode(input logic sel_short, input logic sel_mid);
      if (sel_short)    return WIN_SHORT;
      else if (sel_mid) return WIN_MID;
      else              return WIN_LONG;
   endfunction

   // number of bits the full counter range is shortened by
   function automatic int unsigned win_shrink(input win_e w);
      case (w)
         WIN_SHORT: return 2;
         WIN_MID:   return 1;
         default:   return 0;
      endcase
   endfunction

endpackage

// File: rtl/rtc_trim_window.sv
module rtc_trim_window
   import rtc_trim_pkg::*;
#(
   parameter int CNT_W  = 20,
   parameter int MASK_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              we,
   input  logic              new_add,
   input  logic [MASK_W-1:0] new_mask,
   input  win_e              new_win,
   output logic              act_add,
   output logic [MASK_W-1:0] act_mask,
   output win_e              act_win,
   output logic [CNT_W-1:0]  cnt,
   output logic              at_last,
   output logic              busy
);

   logic              pend_add;
   logic [MASK_W-1:0] pend_mask;
   win_e              pend_win;
   logic [CNT_W-1:0]  lim;
   logic              boundary;

   assign lim      = {CNT_W{1'b1}} >> win_shrink(act_win);
   assign at_last  = (cnt == lim);
   assign boundary = tick & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         act_add   <= 1'b0;
         act_mask  <= '0;
         act_win   <= WIN_LONG;
         pend_add  <= 1'b0;
         pend_mask <= '0;
         pend_win  <= WIN_LONG;
         busy      <= 1'b0;
      end else begin
         if (tick) cnt <= boundary ? '0 : cnt + 1'b1;
         if (boundary) begin
            act_add  <= pend_add;
            act_mask <= pend_mask;
            act_win  <= pend_win;
         end
         if (we) begin
            pend_add  <= new_add;
            pend_mask <= new_mask;
            pend_win  <= new_win;
            busy      <= 1'b1;
         end else if (boundary) begin
            busy <= 1'b0;
         end
      end
   end

   // R2
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_last) |=> (cnt == '0));
   // R8
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> busy);
   // R8
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick && at_last));

endmodule

// File: rtl/rtc_trim_spread.sv
module rtc_trim_spread
   import rtc_trim_pkg::*;
#(
   parameter int CNT_W  = 20,
   parameter int MASK_W = 9
) (
   input  logic [CNT_W-1:0]  cnt,
   input  win_e              act_win,
   input  logic              act_add,
   input  logic [MASK_W-1:0] act_mask,
   output logic              fire,
   output logic              ins_mode
);

   localparam int N_W = MASK_W + 1;
   localparam logic [N_W-1:0] FULL = N_W'(1) << MASK_W;

   logic [CNT_W-1:0]  shifted;
   logic [CNT_W-1:0]  low_mask;
   logic [MASK_W-1:0] slot;
   logic [MASK_W-1:0] rev;
   logic [N_W-1:0]    n_evt;
   int unsigned       sh;

   assign sh       = CNT_W - win_shrink(act_win) - MASK_W;
   assign shifted  = cnt >> sh;
   assign slot     = shifted[MASK_W-1:0];
   assign low_mask = ~({CNT_W{1'b1}} << sh);

   for (genvar gi = 0; gi < MASK_W; gi++) begin : g_rev
      assign rev[gi] = slot[MASK_W-1-gi];
   end

   assign ins_mode = act_add;
   assign n_evt    = act_add ? (FULL - N_W'(act_mask)) : N_W'(act_mask);
   assign fire     = ((cnt & low_mask) == '0) && (N_W'(rev) < n_evt);

endmodule

// File: rtl/rtc_trim_gate.sv
module rtc_trim_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fire,
   input  logic ins_mode,
   output logic tick_out
);

   logic ins_pend;
   logic drop;

   assign drop = fire & ~ins_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_out <= 1'b0;
         ins_pend <= 1'b0;
      end else begin
         tick_out <= (tick & ~drop) | ins_pend;
         ins_pend <= tick & fire & ins_mode;
      end
   end

   // R4
   ins_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_pend |=> tick_out);
   // R3
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && fire && !ins_mode) |=> !tick_out);
   // R9
   out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_out) |-> $past(tick));

endmodule

// File: rtl/rtc_smooth_trim.sv
module rtc_smooth_trim
   import rtc_trim_pkg::*;
#(
   parameter int CNT_W  = 20,
   parameter int MASK_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic              cfg_we,
   input  logic              cfg_add,
   input  logic [MASK_W-1:0] cfg_mask,
   input  logic              cfg_sel_short,
   input  logic              cfg_sel_mid,
   output logic              tick_out,
   output logic              busy
);

   if (CNT_W - 2 < MASK_W) begin : g_bad_cfg
      initial $error("CNT_W must be at least MASK_W + 2");
   end
   if (MASK_W < 1) begin : g_bad_mask
      initial $error("MASK_W must be positive");
   end

   logic              act_add;
   logic [MASK_W-1:0] act_mask;
   win_e              act_win;
   logic [CNT_W-1:0]  cnt;
   logic              at_last;
   logic              fire;
   logic              ins_mode;

   rtc_trim_window #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_in),
      .we       (cfg_we),
      .new_add  (cfg_add),
      .new_mask (cfg_mask),
      .new_win  (win_decode(cfg_sel_short, cfg_sel_mid)),
      .act_add  (act_add),
      .act_mask (act_mask),
      .act_win  (act_win),
      .cnt      (cnt),
      .at_last  (at_last),
      .busy     (busy)
   );

   rtc_trim_spread #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_spread (
      .cnt      (cnt),
      .act_win  (act_win),
      .act_add  (act_add),
      .act_mask (act_mask),
      .fire     (fire),
      .ins_mode (ins_mode)
   );

   rtc_trim_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_in),
      .fire     (fire),
      .ins_mode (ins_mode),
      .tick_out (tick_out)
   );

   // R6
   pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_add && act_mask == '0 && !fire) |=> (tick_out == $past(tick_in)));

endmodule

// File: tb/sim_rtc_smooth_trim.sv
`timescale 1ns/1ps
module sim_rtc_smooth_trim;

   localparam int CNT_W  = 11;
   localparam int MASK_W = 9;
   localparam int FULL   = 1 << MASK_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_in = 1'b0;
   logic cfg_we = 1'b0;
   logic cfg_add = 1'b0;
   logic [MASK_W-1:0] cfg_mask = '0;
   logic cfg_sel_short = 1'b0;
   logic cfg_sel_mid = 1'b0;
   logic tick_out;
   logic busy;

   int checks = 0;
   int failures = 0;
   int out_cnt = 0;
   int mism = 0;
   logic tick_d = 1'b0;
   int cyc = 0;
   bit done = 0;

   // bench model of the active word
   int act_add = 0;
   int act_mask = 0;
   int act_len = 1 << CNT_W;
   int pend_add = 0;
   int pend_mask = 0;
   int pend_len = 1 << CNT_W;

   always #2 clk = ~clk;

   rtc_smooth_trim #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cfg_we(cfg_we),
      .cfg_add(cfg_add), .cfg_mask(cfg_mask), .cfg_sel_short(cfg_sel_short),
      .cfg_sel_mid(cfg_sel_mid), .tick_out(tick_out), .busy(busy)
   );

   always @(posedge clk) begin
      tick_d <= tick_in;
      cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (tick_out) out_cnt++;
      if (tick_out !== tick_d) mism++;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic one_tick();
      @(negedge clk) tick_in = 1'b1;
      @(negedge clk) tick_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic write_cfg(input int add, input int mask, input bit s8, input bit s16);
      @(negedge clk);
      cfg_we = 1'b1; cfg_add = add[0]; cfg_mask = mask[MASK_W-1:0];
      cfg_sel_short = s8; cfg_sel_mid = s16;
      @(negedge clk);
      cfg_we = 1'b0;
      pend_add = add; pend_mask = mask;
      pend_len = s8 ? (1 << (CNT_W-2)) : s16 ? (1 << (CNT_W-1)) : (1 << CNT_W);
      check("R8 busy after write", int'(busy), 1);
   endtask

   // runs one full window under the bench's active word
   task automatic run_window(input bit busy_chk, input string tag);
      int n_evt, half_exp, tot_exp, sgn, half_got;
      n_evt = act_add ? FULL - act_mask : act_mask;
      sgn   = act_add ? 1 : -1;
      half_exp = act_len/2 + sgn * ((n_evt + 1) / 2);
      tot_exp  = act_len + sgn * n_evt;
      out_cnt = 0;
      for (int i = 0; i < act_len/2; i++) one_tick();
      half_got = out_cnt;
      for (int i = act_len/2; i < act_len - 1; i++) one_tick();
      if (busy_chk) check("R8 busy held until boundary", int'(busy), 1);
      one_tick();
      check({"R7 first-half count ", tag}, half_got, half_exp);
      check({"R5 window count ", tag}, out_cnt, tot_exp);
      if (busy_chk) check("R8 busy clear after boundary", int'(busy), 0);
      act_add = pend_add; act_mask = pend_mask; act_len = pend_len;
   endtask

   task automatic trial(input int add, input int mask, input bit s8, input bit s16,
                        input string tag);
      write_cfg(add, mask, s8, s16);
      run_window(1'b1, "old word (R8 deferred)");
      run_window(1'b0, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check("R1 tick_out at reset", int'(tick_out), 0);
      check("R1 busy at reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mism = 0;
      // R6 zero word, longest window (R2)
      run_window(1'b0, "R6 zero word R2 long");
      check("R6 one-cycle passthrough mismatches", mism, 0);
      trial(0, 1,       1'b1, 1'b0, "R3 drop 1 R2 short");
      trial(0, FULL-1,  1'b0, 1'b1, "R3 R5 drop max R2 mid");
      trial(1, 0,       1'b1, 1'b0, "R4 R5 insert max");
      trial(1, 100,     1'b1, 1'b1, "R4 insert 412 R2 short priority");
      trial(0, 3,       1'b0, 1'b0, "R3 drop 3 R2 long");
      trial(0, 0,       1'b0, 1'b1, "R6 zero word R2 mid");
      // R9: zero word again, every output pulse from a tick one cycle earlier
      mism = 0;
      run_window(1'b0, "R9 zero word");
      check("R9 output only from ticks", mism, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cyc >= 190000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule